// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller

This block is the clocked search and result logic of a successive-approximation analog-to-digital converter. It drives a trial code to an external DAC. It reads a single comparator bit, `cmp_hi`, which is high when the analog input sits at or above the analog level of the trial code. It settles one bit of the code per clock, from the most significant bit down to the least significant bit.

When the search ends, the active-low completion output `done_n` falls. A one-cycle capture qualifier, `cap_strobe`, marks the only clock edge at which the finished code can be copied into the held output register `result`. That edge comes after the least significant bit has been stored and coincides with the edge that starts the next conversion in free-running use. The block runs single conversions on request. It can also cycle without pause when `done_n` is wired straight back into the active-low start input `go_n`.

Top module: `sar_ctrl`

## Requirements
- R1: A synchronous active-high `rst` clears `trial` and `result` to zero, drives `done_n` high and `cap_strobe` low, and stops any search in progress.
- R2: Start is sampled only at a clock edge. If `go_n` is low at an enabled rising edge, then after that edge `trial` equals the code with only the MSB set (0x80 at the default width) and `done_n` is high.
- R3: Each enabled edge after the start edge decides one bit, from the MSB down. The bit under test is kept at 1 when `cmp_hi` is 1 and cleared when `cmp_hi` is 0. The next lower bit is then set to 1. After k decided bits, `trial` equals the upper k bits of the converted code, followed by a single 1, followed by zeros.
- R4: `done_n` stays high for the first W-1 enabled edges after the start edge. It falls at the W-th such edge, with the full code in `trial`, and stays low until the next start.
- R5: `cap_strobe` is high only during the one clock cycle after `done_n` falls. At the end of that cycle, `result` takes the finished code.
- R6: `result` changes at no edge other than the one ending a `cap_strobe` cycle, or a reset edge.
- R7: While `en_n` is high, `trial`, `done_n` and `result` hold their values, and a low `go_n` is ignored. When `en_n` returns low, the search resumes where it stopped.
- R8: With `done_n` fed back to `go_n`, conversions follow one another every W+1 clocks. Each one latches its own code into `result` at the edge that restarts the search.
- R9: A start seen while a search is running abandons it. That edge reloads `trial` with only the MSB set and begins a fresh search of W further steps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| en_n | input | 1 | Run enable, active low; high freezes the block |
| go_n | input | 1 | Start request, active low, sampled at the clock edge |
| cmp_hi | input | 1 | Comparator: 1 when the input is at or above the trial level |
| trial | output | W | Trial code driven to the DAC |
| done_n | output | 1 | Conversion complete, active low |
| cap_strobe | output | 1 | One-cycle capture window after completion |
| result | output | W | Latched code of the last finished conversion |

## Verification
The bench runs codes at both ends of the scale and on each side of mid-scale (0, 1, 127, 128, 254, 255). These catch a search that loses the LSB by capturing at the falling edge of `done_n`, and a search that inverts the sense of the comparator. It times the edge at which `done_n` falls and the one-cycle life of `cap_strobe`. Completion one clock early or late, or a capture on the restart edge after `trial` has been reloaded with 0x80, shows up as a wrong count or as a `result` of 0x80. It freezes a search halfway through with `en_n` while `go_n` is low, and then restarts a running search. A block that ignored the enable, or that finished the old search instead of restarting, would produce the wrong code. Free-running mode checks that every result belongs to its own conversion, and a reset in mid-search checks that all state clears.

// File: rtl/sar_ctrl.sv
module sar_ctrl #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_n,
  input  logic         go_n,
  input  logic         cmp_hi,
  output logic [W-1:0] trial,
  output logic         done_n,
  output logic         cap_strobe,
  output logic [W-1:0] result
);
  localparam int PW = (W > 1) ? $clog2(W) : 1;
  localparam logic [PW-1:0] TOP = PW'(W - 1);
  localparam logic [W-1:0] SEED = {1'b1, {(W-1){1'b0}}};

  logic          busy;
  logic          fresh;
  logic [PW-1:0] pos;
  logic [W-1:0]  decided;

  always_comb begin
    decided = trial;
    decided[pos] = cmp_hi;
    if (pos != '0) decided[pos - PW'(1)] = 1'b1;
  end

  assign cap_strobe = fresh & ~done_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      trial  <= '0;
      result <= '0;
      busy   <= 1'b0;
      fresh  <= 1'b0;
      done_n <= 1'b1;
      pos    <= TOP;
    end else if (!en_n) begin
      fresh <= 1'b0;
      if (cap_strobe) result <= trial;
      if (!go_n) begin
        trial  <= SEED;
        pos    <= TOP;
        busy   <= 1'b1;
        done_n <= 1'b1;
      end else if (busy) begin
        trial <= decided;
        if (pos == '0) begin
          busy   <= 1'b0;
          done_n <= 1'b0;
          fresh  <= 1'b1;
        end else begin
          pos <= pos - PW'(1);
        end
      end
    end
  end
endmodule

module sar_ctrl_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         en_n,
  input logic         go_n,
  input logic [W-1:0] trial,
  input logic         done_n,
  input logic         cap_strobe,
  input logic [W-1:0] result
);
  int   steps;
  logic running;

  always_ff @(posedge clk) begin
    if (rst) begin
      steps   <= 0;
      running <= 1'b0;
    end else if (!en_n) begin
      if (!go_n) begin
        steps   <= 0;
        running <= 1'b1;
      end else if (running) begin
        steps <= steps + 1;
        if (steps + 1 == W) running <= 1'b0;
      end
    end
  end

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (trial == '0 && result == '0 && done_n && !cap_strobe));

  assert_start_seeds_R2: assert property (@(posedge clk) disable iff (rst)
    (!en_n && !go_n) |=> (trial == {1'b1, {(W-1){1'b0}}} && done_n));

  assert_done_on_count_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(done_n) |-> (steps == W));

  assert_strobe_after_fall_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(done_n) |-> cap_strobe);

  assert_strobe_one_cycle_R5: assert property (@(posedge clk) disable iff (rst)
    (cap_strobe && !en_n) |=> !cap_strobe);

  assert_result_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    !(cap_strobe && !en_n) |=> $stable(result));

  assert_hold_disabled_R7: assert property (@(posedge clk) disable iff (rst)
    en_n |=> ($stable(trial) && $stable(done_n)));
endmodule

bind sar_ctrl sar_ctrl_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .en_n(en_n), .go_n(go_n), .trial(trial),
  .done_n(done_n), .cap_strobe(cap_strobe), .result(result)
);

// File: tb/tb_sar_ctrl.sv
module tb_sar_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en_n = 1'b0;
  logic       go_drv_n = 1'b1;
  logic       cont = 1'b0;
  logic [7:0] target = 8'd0;
  logic       go_n;
  logic       cmp_hi;
  logic [7:0] trial;
  logic       done_n;
  logic       cap_strobe;
  logic [7:0] result;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  localparam logic [15:0] VEC [6] = '{
    16'h0000, 16'h0101, 16'h7F7F, 16'h8080, 16'hFEFE, 16'hFFFF
  };

  always #2 clk = ~clk;

  assign cmp_hi = (target >= trial);
  assign go_n   = go_drv_n & (cont ? done_n : 1'b1);

  sar_ctrl #(.W(8)) dut (
    .clk(clk), .rst(rst), .en_n(en_n), .go_n(go_n), .cmp_hi(cmp_hi),
    .trial(trial), .done_n(done_n), .cap_strobe(cap_strobe), .result(result)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] partial(input logic [7:0] code, input int k);
    logic [7:0] m;
    m = 8'hFF << (8 - k);
    return (code & m) | ((k < 8) ? (8'h80 >> k) : 8'h00);
  endfunction

  task automatic kick();
    @(negedge clk) go_drv_n = 1'b0;
    @(negedge clk) go_drv_n = 1'b1;
  endtask

  task automatic single(input logic [7:0] tgt, input logic [7:0] exp);
    logic [7:0] held;
    @(negedge clk) begin target = tgt; go_drv_n = 1'b0; end
    @(negedge clk) go_drv_n = 1'b1;
    chk(trial == 8'h80, "R2 seed", trial, 8'h80);
    chk(done_n == 1'b1, "R2 done_n high", done_n, 1);
    for (int s = 1; s <= 8; s++) begin
      @(negedge clk);
      chk(trial == partial(tgt, s), "R3 step", trial, partial(tgt, s));
      if (s < 8) chk(done_n == 1'b1, "R4 early", done_n, 1);
    end
    chk(done_n == 1'b0, "R4 done_n fell", done_n, 0);
    chk(cap_strobe == 1'b1, "R5 strobe", cap_strobe, 1);
    @(negedge clk);
    chk(result == exp, "R5 latched", result, exp);
    chk(cap_strobe == 1'b0, "R5 strobe width", cap_strobe, 0);
    chk(done_n == 1'b0, "R4 stays low", done_n, 0);
    held = result;
    target = ~tgt;
    repeat (3) @(negedge clk);
    chk(result == held, "R6 held", result, held);
  endtask

  initial begin
    #(4 * 100000);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(trial == 8'h00, "R1 trial", trial, 0);
    chk(result == 8'h00, "R1 result", result, 0);
    chk(done_n == 1'b1, "R1 done_n", done_n, 1);
    chk(cap_strobe == 1'b0, "R1 strobe", cap_strobe, 0);
    rst = 1'b0;

    for (int i = 0; i < 6; i++) single(VEC[i][15:8], VEC[i][7:0]);

    @(negedge clk) begin target = 8'hA5; go_drv_n = 1'b0; end
    @(negedge clk) go_drv_n = 1'b1;
    repeat (3) @(negedge clk);
    en_n = 1'b0;
    begin
      logic [7:0] frozen;
      frozen = trial;
      en_n = 1'b1;
      go_drv_n = 1'b0;
      repeat (4) @(negedge clk);
      chk(trial == frozen, "R7 trial frozen", trial, frozen);
      chk(done_n == 1'b1, "R7 done_n frozen", done_n, 1);
      chk(result == 8'hFF, "R7 result frozen", result, 8'hFF);
    end
    go_drv_n = 1'b1;
    en_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(done_n == 1'b1, "R7 resume count", done_n, 1);
    @(negedge clk);
    chk(done_n == 1'b0 && trial == 8'hA5, "R7 resumed code", trial, 8'hA5);
    @(negedge clk);
    chk(result == 8'hA5, "R7 resumed result", result, 8'hA5);

    @(negedge clk) begin target = 8'h3C; go_drv_n = 1'b0; end
    @(negedge clk) go_drv_n = 1'b1;
    repeat (3) @(negedge clk);
    target = 8'hC3;
    go_drv_n = 1'b0;
    @(negedge clk) go_drv_n = 1'b1;
    chk(trial == 8'h80 && done_n == 1'b1, "R9 reseed", trial, 8'h80);
    repeat (7) @(negedge clk);
    chk(done_n == 1'b1, "R9 not early", done_n, 1);
    @(negedge clk);
    chk(done_n == 1'b0 && trial == 8'hC3, "R9 new code", trial, 8'hC3);
    @(negedge clk);
    chk(result == 8'hC3, "R9 result", result, 8'hC3);

    cont = 1'b1;
    target = VEC[0][15:8];
    kick();
    for (int i = 0; i < 6; i++) begin
      int cnt;
      cnt = 0;
      do begin
        @(negedge clk);
        cnt++;
        if (cnt == 1 && i > 0)
          chk(result == VEC[i-1][7:0], "R8 prior result", result, VEC[i-1][7:0]);
      end while (done_n && cnt < 20);
      chk(cnt == ((i == 0) ? 8 : 9), "R8 period", cnt, (i == 0) ? 8 : 9);
      chk(trial == VEC[i][7:0], "R8 code", trial, VEC[i][7:0]);
      if (i < 5) target = VEC[i+1][15:8];
      else cont = 1'b0;
    end
    @(negedge clk);
    chk(result == VEC[5][7:0], "R8 last result", result, VEC[5][7:0]);
    chk(done_n == 1'b0, "R8 stopped", done_n, 0);

    @(negedge clk) begin target = 8'h77; go_drv_n = 1'b0; end
    @(negedge clk) go_drv_n = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    chk(trial == 8'h00, "R1 mid trial", trial, 0);
    chk(result == 8'h00, "R1 mid result", result, 0);
    chk(done_n == 1'b1, "R1 mid done_n", done_n, 1);
    chk(cap_strobe == 1'b0, "R1 mid strobe", cap_strobe, 0);
    repeat (3) @(negedge clk);
    chk(trial == 8'h00, "R1 stays idle", trial, 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule